// File: doc/BRIEF.md
# Sprite DMA Window Decoder

This block produces the per-line permission signal for sprite DMA. A 10-bit horizontal position counter, held inside the block, returns to zero on a line-start pulse and climbs by one each clock. The permission opens when the counter passes position 20 and closes when it passes position 772. The open interval is kept in a set/reset flag, and the flag drives the registered output `dma_allow`.

The block does not compare the full counter against each bound. The counter only rises within a line, so each bound is found by testing only those counter bits that are 1 in the bound value. No smaller count has all of those bits set. The start detector therefore looks at bits 4 and 2, and the stop detector looks at bits 9, 8 and 2. That is five compared bits in place of twenty. A per-line done bit stops a later value such as 788 from opening the window again. A parameter can swap in full equality comparators for comparison.

Top module: `sprite_dma_window`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `hpos` is 0 and `dma_allow` is 0.
- R2: A cycle with `line_start` high makes the next cycle show `hpos` = 0 and `dma_allow` = 0, whatever the position and flag state were. This takes priority over counting and over both edge detectors.
- R3: Without `line_start`, `hpos` rises by exactly one per cycle and holds at 1023 once it gets there.
- R4: The start edge is detected when counter bits 4 and 2 are both 1, which first happens at position 20. `dma_allow` goes high one cycle later, so its first high cycle in a line is the one where `hpos` = 21.
- R5: The stop edge is detected when counter bits 9, 8 and 2 are all 1, which first happens at position 772. `dma_allow` is still high while `hpos` = 772 and is low from `hpos` = 773.
- R6: Once the stop edge has fired in a line, `dma_allow` stays low for the rest of that line. This holds at 788, where the start and stop patterns both match, and at every later position up to 1023.
- R7: At every cycle, `dma_allow` equals a full-width reference: high exactly when 21 ≤ `hpos` ≤ 772. This is the allowed range 20 to 771, shifted by the one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that starts a new line |
| hpos | output | 10 | Current horizontal position |
| dma_allow | output | 1 | Registered sprite DMA permission |

## Verification
There are two same-cycle collisions. The first is a line-start pulse landing exactly when an edge detector matches. The bench provokes it by pulsing `line_start` at positions 20, 772 and 788. Each time it expects `hpos` = 0 with `dma_allow` low on the next cycle, and then a normal window on the new line. The second is the start and stop patterns matching together at 788. A full sweep judges it by requiring `dma_allow` to stay low there, with stop and done taking precedence over start. Random line lengths then compare every cycle against the 21 to 772 reference.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  // Result of the two window-edge detectors for one cycle.
  typedef struct packed {
    logic open_hit;
    logic close_hit;
  } sdw_hits_t;

endpackage

// File: rtl/sdw_hcount.sv
module sdw_hcount #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Climbs once per cycle, parks at its top value so it never wraps
  // inside a line (the edge detectors rely on a monotonic count).
  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdw_edge_match.sv
module sdw_edge_match #(
  parameter int CNT_W    = 10,
  parameter int EDGE_POS = 20,
  parameter bit FULL_CMP = 1'b0
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  // For an up-counter starting at zero, the first value that contains
  // every one-bit of EDGE_POS is EDGE_POS itself, so those bits alone
  // form the detection mask.
  localparam logic [CNT_W-1:0] EDGE_VAL  = CNT_W'(EDGE_POS);
  localparam logic [CNT_W-1:0] EDGE_MASK = EDGE_VAL;

  generate
    if (FULL_CMP) begin : g_full
      assign hit = (cnt == EDGE_VAL);
    end else begin : g_partial
      assign hit = ((cnt & EDGE_MASK) == EDGE_MASK);
    end
  endgenerate

endmodule

// File: rtl/sdw_window_flag.sv
module sdw_window_flag
  import sdw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_start,
  input  sdw_hits_t hits,
  output logic      allow
);

  logic closed_q;

  // Priority: line start / reset, then close, then open (blocked once
  // the window has closed in this line).
  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      allow    <= 1'b0;
      closed_q <= 1'b0;
    end else if (hits.close_hit) begin
      allow    <= 1'b0;
      closed_q <= 1'b1;
    end else if (hits.open_hit && !closed_q) begin
      allow    <= 1'b1;
    end
  end

endmodule

// File: rtl/sprite_dma_window.sv
module sprite_dma_window
  import sdw_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int OPEN_POS  = 20,
  parameter int CLOSE_POS = 772,
  parameter bit FULL_CMP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  output logic [CNT_W-1:0] hpos,
  output logic             dma_allow
);

  sdw_hits_t hits;

  sdw_hcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .cnt        (hpos)
  );

  sdw_edge_match #(.CNT_W(CNT_W), .EDGE_POS(OPEN_POS), .FULL_CMP(FULL_CMP)) u_open (
    .cnt (hpos),
    .hit (hits.open_hit)
  );

  sdw_edge_match #(.CNT_W(CNT_W), .EDGE_POS(CLOSE_POS), .FULL_CMP(FULL_CMP)) u_close (
    .cnt (hpos),
    .hit (hits.close_hit)
  );

  sdw_window_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .hits       (hits),
    .allow      (dma_allow)
  );

endmodule

// File: rtl/sdw_window_chk.sv
module sdw_window_chk #(
  parameter int CNT_W     = 10,
  parameter int OPEN_POS  = 20,
  parameter int CLOSE_POS = 772
) (
  input logic             clk,
  input logic             rst,
  input logic             line_start,
  input logic [CNT_W-1:0] hpos,
  input logic             dma_allow
);

  localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FIRST_HI = CNT_W'(OPEN_POS + 1);
  localparam logic [CNT_W-1:0] FIRST_LO = CNT_W'(CLOSE_POS + 1);
  localparam logic [CNT_W-1:0] LAST_HI  = CNT_W'(CLOSE_POS);

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (hpos == '0) && !dma_allow); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!line_start && hpos != TOP) |=> hpos == $past(hpos) + 1'b1); // R3

  AST_COUNT_PARK: assert property (@(posedge clk) disable iff (rst)
    (!line_start && hpos == TOP) |=> hpos == TOP); // R3

  AST_OPEN_POINT: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_allow) |-> hpos == FIRST_HI); // R4

  AST_CLOSE_POINT: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_allow) && !$past(line_start)) |-> hpos == FIRST_LO); // R5

  AST_NO_REOPEN: assert property (@(posedge clk) disable iff (rst)
    (hpos > LAST_HI) |-> !dma_allow); // R6

  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (hpos < FIRST_HI) |-> !dma_allow); // R7

endmodule

bind sprite_dma_window sdw_window_chk #(
  .CNT_W(CNT_W), .OPEN_POS(OPEN_POS), .CLOSE_POS(CLOSE_POS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_start (line_start),
  .hpos       (hpos),
  .dma_allow  (dma_allow)
);

// File: tb/sim_sprite_dma_window.sv
module sim_sprite_dma_window;

  localparam int W   = 10;
  localparam int TOP = 1023;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         line_start = 1'b0;
  logic [W-1:0] hpos;
  logic         dma_allow;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit after_ls = 1'b0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sprite_dma_window u0 (
    .clk(clk), .rst(rst), .line_start(line_start),
    .hpos(hpos), .dma_allow(dma_allow)
  );

  // Reference built from full-width comparisons.
  function automatic bit ref_allow(int c);
    return (c >= 21) && (c <= 772);
  endfunction

  function automatic int next_cnt(int c, bit ls);
    if (ls) return 0;
    return (c == TOP) ? TOP : c + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (model pos %0d)", req, act, exp, exp_cnt);
    end
  endtask

  task automatic check_now();
    string ra;
    check("R3", int'(hpos), exp_cnt);
    if (after_ls)            ra = "R2";
    else if (exp_cnt == 21)  ra = "R4";
    else if (exp_cnt == 772 || exp_cnt == 773) ra = "R5";
    else if (exp_cnt > 773)  ra = "R6";
    else                     ra = "R7";
    check(ra, int'(dma_allow), int'(ref_allow(exp_cnt)));
  endtask

  // Drive line_start for one edge, then check at the falling edge.
  task automatic step(bit ls);
    line_start = ls;
    @(posedge clk);
    exp_cnt  = next_cnt(exp_cnt, ls);
    after_ls = ls;
    @(negedge clk);
    line_start = 1'b0;
    check_now();
  endtask

  task automatic run_to(int target);
    while (exp_cnt < target) step(1'b0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", int'(hpos), 0);
    check("R1", int'(dma_allow), 0);
    rst = 1'b0;
    @(posedge clk);
    exp_cnt = 1;
    @(negedge clk);
    check("R1", int'(dma_allow), 0);
    check("R3", int'(hpos), 1);

    // Full sweep including saturation and the 788 dual match (R6).
    run_to(TOP);
    repeat (5) step(1'b0);

    // Line start colliding with the open match at 20 (R2).
    step(1'b1);
    run_to(20);
    step(1'b1);
    check("R2", int'(dma_allow), 0);
    // Line start at 772, then a clean line must still open (R2, R4).
    run_to(772);
    step(1'b1);
    run_to(25);
    check("R4", int'(dma_allow), 1);
    // Line start at 788 after the window closed (R2, R6).
    run_to(788);
    check("R6", int'(dma_allow), 0);
    step(1'b1);
    run_to(TOP);

    // Random line lengths.
    for (int i = 0; i < 40; i++) begin
      int len;
      len = $urandom_range(1100, 0);
      step(1'b1);
      for (int k = 0; k < len; k++) step(1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule